// File: doc/BRIEF.md
# Frame-Checked Serial Command Port

This block is the serial slave port of a half-bridge driver controller. A host selects it with an active-low chip select, clocks command bits in on a serial data line, and at the same time receives a diagnostic word on a tri-state serial output. All three serial inputs are oversampled by the fast system clock through synchronisers. The frame is accepted only when the number of clocked bits is a nonzero whole multiple of the word width. That rule lets several ports share one chip select in a daisy chain, where each port forwards the bits it receives to the next port.

On an accepted frame, the most recent word received is latched as the command. A one-cycle strobe marks the update for the protection logic behind the port. The port also decodes the command into per-bridge enables, the two protection-mode enables and a status-clear strobe. The status word that is shifted out is taken from a parallel input while the port is deselected. Its bit 0, the thermal warning, appears on the serial output as soon as the select falls, even before any clock edge.

Top module: `spi_frame_port`

## Requirements
- R1: After reset, the command word, all decoded enables, the strobe outputs and the output-enable are all 0, provided select is high.
- R2: The serial output enable `so_oe` is 0 whenever `csb_i` is high and 1 whenever it is low.
- R3: Once select falls, `so_d` shows `status_i[0]` with no serial clock edge.
- R4: The first 16 bits read on rising serial clock edges are `status_i`, sent least significant bit first, as sampled before select fell.
- R5: Bit n, for n at 16 or above, read on a rising edge is the serial input bit that was clocked in at rising edge n-15. The input is therefore repeated 16 clocks later.
- R6: A 16-bit frame closed with the serial clock low latches its bits into `cmd_word`, with the first bit at bit 0, and pulses `cmd_valid`.
- R7: A frame of 32 or 48 bits latches only the last 16 bits it received.
- R8: A frame whose bit count is zero or not a multiple of 16 leaves `cmd_word` unchanged and gives no `cmd_valid`.
- R9: A frame that closes while the serial clock is high is rejected, even when its bit count is a multiple of 16.
- R10: `cmd_valid` is high for exactly one system cycle for each accepted frame.
- R11: The decoded outputs follow `cmd_word`. Low-side enable of bridge b is bit 1+2b and high-side enable is bit 2+2b. Overcurrent shutdown enable is bit 13 and overvoltage lockout enable is bit 15.
- R12: `status_clr` pulses together with `cmd_valid` only when bit 0 of the new command is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| status_i | input | 16 | Diagnostic word to shift out |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out drive enable |
| cmd_word | output | 16 | Latched command word |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| ls_en | output | 3 | Low-side enables per bridge |
| hs_en | output | 3 | High-side enables per bridge |
| ocd_en | output | 1 | Overcurrent shutdown enable |
| ovlo_en | output | 1 | Overvoltage lockout enable |
| status_clr | output | 1 | Status reset strobe |

## Verification
Two rules can decide the same frame-close event: the bit-count check and the rule that the serial clock must be low. The bench provokes both in one frame. It clocks a full multiple of 16 bits but leaves the last rising edge standing high when select rises. A correct port must then keep the previous command and give no strobe. Random frames of arbitrary length also mix the two conditions. Each close is judged against a bench prediction made from the bit count and the clock level.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int unsigned WORD_BITS   = 16;
  localparam int unsigned POS_CLEAR   = 0;
  localparam int unsigned POS_BRIDGE0 = 1;
  localparam int unsigned POS_OCD     = 13;
  localparam int unsigned POS_OVLO    = 15;

  // frame accepted: some bits clocked, whole words only, clock parked low
  function automatic logic frame_accept(input logic seen, input int unsigned residue,
                                        input logic sclk_level);
    return seen && (residue == 0) && !sclk_level;
  endfunction

  // next bit counter value, wrapping at the word width
  function automatic int unsigned residue_next(input int unsigned residue,
                                               input int unsigned width);
    return (residue == width - 1) ? 0 : residue + 1;
  endfunction

  function automatic int unsigned low_side_pos(input int unsigned bridge);
    return POS_BRIDGE0 + 2 * bridge;
  endfunction

  function automatic int unsigned high_side_pos(input int unsigned bridge);
    return POS_BRIDGE0 + 2 * bridge + 1;
  endfunction
endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spf_rx.sv
module spf_rx #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_level,
  input  logic              si_level,
  output logic [WORD_W-1:0] rx_shift,
  output logic [CNT_W-1:0]  residue,
  output logic              seen,
  output logic              accept,
  output logic [WORD_W-1:0] cmd_q,
  output logic              valid_q
);
  import spf_pkg::*;

  assign accept = frame_accept(seen, int'(residue), sclk_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_shift <= '0;
      residue  <= '0;
      seen     <= 1'b0;
    end else if (cs_fall) begin
      residue <= '0;
      seen    <= 1'b0;
    end else if (sclk_rise) begin
      rx_shift <= {si_level, rx_shift[WORD_W-1:1]};
      residue  <= CNT_W'(residue_next(int'(residue), WORD_W));
      seen     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cs_rise && accept;
      if (cs_rise && accept) cmd_q <= rx_shift;
    end
  end
endmodule

// File: rtl/spf_tx.sv
module spf_tx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_level,
  input  logic              sclk_fall,
  input  logic              seen,
  input  logic              feed_bit,
  input  logic [WORD_W-1:0] status_i,
  output logic              so_bit
);
  logic [WORD_W-1:0] tx_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tx_shift <= '0;
    else if (cs_level)         tx_shift <= status_i;
    else if (sclk_fall && seen) tx_shift <= {feed_bit, tx_shift[WORD_W-1:1]};
  end

  assign so_bit = tx_shift[0];
endmodule

// File: rtl/spi_frame_port.sv
module spi_frame_port #(
  parameter int unsigned WORD_W      = spf_pkg::WORD_BITS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_BRIDGES = 3,
  localparam int unsigned CNT_W      = $clog2(WORD_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csb_i,
  input  logic                   sclk_i,
  input  logic                   si_i,
  input  logic [WORD_W-1:0]      status_i,
  output logic                   so_d,
  output logic                   so_oe,
  output logic [WORD_W-1:0]      cmd_word,
  output logic                   cmd_valid,
  output logic [NUM_BRIDGES-1:0] ls_en,
  output logic [NUM_BRIDGES-1:0] hs_en,
  output logic                   ocd_en,
  output logic                   ovlo_en,
  output logic                   status_clr
);
  import spf_pkg::*;

  logic [2:0] sync_lv;
  logic cs_w, sclk_w, si_w;
  logic cs_q, sclk_q;
  logic cs_fall_w, close_w, sclk_rise_w, sclk_fall_w;
  logic [WORD_W-1:0] rx_shift_w;
  logic [CNT_W-1:0]  residue_w;
  logic seen_w, accept_w;

  spf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({csb_i, sclk_i, si_i}), .sync_o(sync_lv)
  );
  assign cs_w   = sync_lv[2];
  assign sclk_w = sync_lv[1];
  assign si_w   = sync_lv[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_w;
      sclk_q <= sclk_w;
    end
  end

  assign cs_fall_w   = cs_q && !cs_w;
  assign close_w     = !cs_q && cs_w;
  assign sclk_rise_w = !cs_w && !sclk_q && sclk_w;
  assign sclk_fall_w = !cs_w && sclk_q && !sclk_w;

  spf_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall_w), .cs_rise(close_w),
    .sclk_rise(sclk_rise_w), .sclk_level(sclk_w), .si_level(si_w),
    .rx_shift(rx_shift_w), .residue(residue_w), .seen(seen_w), .accept(accept_w),
    .cmd_q(cmd_word), .valid_q(cmd_valid)
  );

  spf_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_level(cs_w), .sclk_fall(sclk_fall_w),
    .seen(seen_w), .feed_bit(rx_shift_w[WORD_W-1]), .status_i(status_i), .so_bit(so_d)
  );

  // output driver follows the raw select so the warning bit shows at once
  assign so_oe = !csb_i;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    assign ls_en[b] = cmd_word[low_side_pos(b)];
    assign hs_en[b] = cmd_word[high_side_pos(b)];
  end
  assign ocd_en     = cmd_word[POS_OCD];
  assign ovlo_en    = cmd_word[POS_OVLO];
  assign status_clr = cmd_valid && cmd_word[POS_CLEAR];
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] cmd_word,
  input logic              cmd_valid,
  input logic              close_w,
  input logic [CNT_W-1:0]  residue_w,
  input logic              seen_w,
  input logic              sclk_w
);
  // R10
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word != $past(cmd_word)) |-> cmd_valid);

  // R6
  valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(close_w) && $past(seen_w) && ($past(residue_w) == '0)));

  // R9
  valid_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(sclk_w));
endmodule

bind spi_frame_port spf_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_spf_checker (
  .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
  .close_w(close_w), .residue_w(residue_w), .seen_w(seen_w), .sclk_w(sclk_w)
);

// File: tb/test_spi_frame_port.sv
module test_spi_frame_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csb = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [15:0] status = '0;
  logic so_d, so_oe, cmd_valid, ocd_en, ovlo_en, status_clr;
  logic [15:0] cmd_word;
  logic [2:0] ls_en, hs_en;

  int errors = 0, checks = 0;
  int vcount = 0, ccount = 0, dbl = 0;
  logic prev_valid = 1'b0;
  logic [15:0] exp_cmd = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_frame_port i_spi_frame_port (
    .clk(clk), .rst_n(rst_n), .csb_i(csb), .sclk_i(sclk), .si_i(si), .status_i(status),
    .so_d(so_d), .so_oe(so_oe), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .ls_en(ls_en), .hs_en(hs_en), .ocd_en(ocd_en), .ovlo_en(ovlo_en), .status_clr(status_clr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) vcount++;
      if (status_clr) ccount++;
      if (cmd_valid && prev_valid) dbl++;
      prev_valid = cmd_valid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic model_accept(input int nbits, input logic end_high);
    return (nbits > 0) && (nbits % 16 == 0) && !end_high;
  endfunction

  task automatic check_decode();
    for (int b = 0; b < 3; b++) begin
      chk("R11 ls", ls_en[b], exp_cmd[1 + 2*b]);
      chk("R11 hs", hs_en[b], exp_cmd[2 + 2*b]);
    end
    chk("R11 ocd", ocd_en, exp_cmd[13]);
    chk("R11 ovlo", ovlo_en, exp_cmd[15]);
  endtask

  task automatic frame(input int nbits, input logic [63:0] bits, input logic end_high,
                       input logic [15:0] st);
    int v0, c0;
    logic acc;
    string tag;
    v0 = vcount; c0 = ccount;
    status = st;
    cyc(4);
    chk("R2 idle", so_oe, 1'b0);
    csb = 1'b0;
    cyc(2);
    chk("R2 active", so_oe, 1'b1);
    chk("R3", so_d, st[0]);
    cyc(4);
    for (int i = 0; i < nbits; i++) begin
      si = bits[i];
      cyc(4);
      if (i < 16) chk("R4", so_d, st[i]);
      else        chk("R5", so_d, bits[i-16]);
      sclk = 1'b1;
      cyc(8);
      if (!(end_high && i == nbits - 1)) begin
        sclk = 1'b0;
        cyc(4);
      end
    end
    csb = 1'b1;
    cyc(2);
    chk("R2 release", so_oe, 1'b0);
    cyc(10);
    sclk = 1'b0;
    acc = model_accept(nbits, end_high);
    if (acc) begin
      exp_cmd = bits[nbits-16 +: 16];
      tag = (nbits > 16) ? "R7" : "R6";
    end else begin
      tag = end_high ? "R9" : "R8";
    end
    chk(tag, cmd_word, exp_cmd);
    chk({tag, " strobe"}, vcount - v0, acc ? 1 : 0);
    chk("R12", ccount - c0, (acc && exp_cmd[0]) ? 1 : 0);
    check_decode();
    cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(5);
    chk("R1 cmd", cmd_word, 16'h0);
    chk("R1 valid", cmd_valid, 1'b0);
    chk("R1 oe", so_oe, 1'b0);
    chk("R1 clr", status_clr, 1'b0);
    check_decode();
    rst_n = 1'b1;
    cyc(5);
    // directed
    frame(16, 64'h0000_0000_0000_A55B, 1'b0, 16'h8001);
    frame(16, 64'h0000_0000_0000_FFFE, 1'b0, 16'h1234);
    frame(32, 64'h0000_0000_2AAA_C3C3, 1'b0, 16'h0F0E);
    frame(48, 64'h0000_8123_0001_FFFF, 1'b0, 16'hFFFF);
    frame(15, 64'h0000_0000_0000_7FFF, 1'b0, 16'h0002);
    frame(17, 64'h0000_0000_0001_5555, 1'b0, 16'h0003);
    frame(0,  64'h0, 1'b0, 16'h0001);
    frame(16, 64'h0000_0000_0000_0001, 1'b1, 16'h0000);
    frame(32, 64'h0000_0000_1111_2222, 1'b1, 16'h5A5A);
    frame(16, 64'h0000_0000_0000_0041, 1'b0, 16'hC000);
    // random
    for (int k = 0; k < 30; k++) begin
      int n;
      logic eh;
      logic [63:0] b;
      logic [15:0] s;
      n = ($urandom % 2) ? 16 * (1 + $urandom % 3) : int'($urandom % 50);
      eh = ($urandom % 8) == 0;
      b = {$urandom, $urandom};
      s = 16'($urandom);
      if (eh && n == 0) n = 16;
      frame(n, b, eh, s);
    end
    chk("R10", dbl, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule